// File: doc/BRIEF.md
# SDRAM Command Mode Engine

This unit turns one software-written command word into a single SDRAM command on the shared command pins (RAS, CAS, WE, address) and on the chip selects and clock enables of up to two external devices. The word holds a 3-bit operation code, a two-bit device mask, a repeat count stored minus one and a mode value. The unit reports busy until every issue of the command has gone out and every gap after it has elapsed. Software waits for busy to clear before it writes the next word. A word written while busy is discarded.

The unit also runs the periodic refresh countdown. A rate value sets the period. When the countdown expires, a refresh request is raised. The engine serves the request at the next idle cycle with one auto-refresh to every device whose clock enable is high. Row-cycle and precharge delays come from one shared set of timing inputs and apply to both devices, given as plain cycle counts.

States: `ST_IDLE` (not busy, pins quiet), `ST_ISSUE` (one cycle driving the command), `ST_GAP` (waiting out a row-cycle or precharge delay). Transitions:
- idle→issue on an accepted write or on a served refresh request.
- issue→gap after precharge-all or auto-refresh.
- issue→idle after any other operation.
- gap→issue while repeats remain.
- gap→idle when the last delay has expired.

Top module: `sdram_cmd_engine`

## Requirements
- R1: After reset all chip selects, RAS, CAS and WE are high (inactive), the address is zero, both clock enables are low and busy is low.
- R2: Command word fields:
  - bits [2:0] hold the operation code: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down, 7 reserved.
  - bit 4 targets device 1, which is pin index 1 of the chip selects and clock enables.
  - bit 3 targets device 2, which is pin index 0.
  - bits [8:5] hold the repeat count minus one.
  - bits [21:9] hold the mode value.
- R3: The command appears in the cycle after an accepted write, for exactly one cycle, with the chip select low only for targeted devices:
  - precharge all drives RAS low, CAS high, WE low and address bit 10 high.
  - auto-refresh drives RAS and CAS low and WE high.
  - load mode drives RAS, CAS and WE low, with the mode value on the address.
- R4: Normal and clock-enable commands raise the clock enable of the targeted devices. Power-down and self-refresh lower it. The change is visible in the issue cycle and holds until another such command. Self-refresh drives the auto-refresh pin pattern in its issue cycle.
- R5: Busy is high from the cycle after an accepted write until the command completes. A write made while busy is ignored entirely.
- R6: An auto-refresh issues repeat+1 times. Each issue cycle is followed by max(trc_cyc,1) gap cycles, including after the last issue, so busy lasts (repeat+1)*(max(trc_cyc,1)+1) cycles.
- R7: After precharge all, busy stays high for max(trp_cyc,1) further cycles. Every other operation except auto-refresh keeps busy for its issue cycle only.
- R8: One set of timing inputs governs the gaps for commands to either device, including commands sent to both.
- R9: Refresh countdown:
  - writing the rate loads the countdown and clears any pending request.
  - a nonzero rate N raises a request every N+1 cycles, which the idle engine serves with one auto-refresh to every device whose clock enable is high.
  - a zero rate stops refreshes.
- R10: Normal, clock-enable, power-down and reserved code 7 drive no command (all chip selects high). Code 7 leaves the clock enables unchanged. A refresh request with no clock enable high is dropped without any pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Command word (code, targets, repeat, mode) |
| rate_wr | input | 1 | Refresh rate write strobe |
| rate_val | input | 13 | Refresh countdown reload value |
| trc_cyc | input | 4 | Row-cycle delay in cycles |
| trp_cyc | input | 4 | Precharge delay in cycles |
| sd_cs_n | output | 2 | Chip selects, index 1 device 1, index 0 device 2 |
| sd_cke | output | 2 | Clock enables, same indexing |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | 13 | Address lines |
| busy | output | 1 | Command in progress |

## Verification
The bench builds the engine with its default widths: a 13-bit mode value, a 4-bit repeat field, 4-bit delays and a 13-bit rate. This is enough to reach the full 16-issue repeat range and a mode value that sets address bit 10 together with other bits.

The delays and the rate are ports, so a single build covers the zero delay that is raised to one, nonzero delays of 2, 3 and 5 cycles, and refresh periods of 5 and 10 cycles. It also covers a refresh period that expires while every clock enable is low.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        OP_NORMAL    = 3'd0,
        OP_CLK_ON    = 3'd1,
        OP_PRE_ALL   = 3'd2,
        OP_AUTO_RF   = 3'd3,
        OP_LOAD_MODE = 3'd4,
        OP_SELF_RF   = 3'd5,
        OP_PWR_DOWN  = 3'd6,
        OP_RESERVED  = 3'd7
    } sd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_e;

    localparam int NUM_DEV = 2;
    localparam int OP_W    = 3;

endpackage

// File: rtl/sdram_rfsh_timer.sv
module sdram_rfsh_timer #(
    parameter int RATE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              take,
    output logic              pend
);

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] cnt_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (rate_wr) begin
            rate_q <= rate_in;
            cnt_q  <= rate_in;
            pend_q <= 1'b0;
        end else begin
            if (take) begin
                pend_q <= 1'b0;
            end
            if (rate_q != '0) begin
                if (cnt_q == '0) begin
                    pend_q <= 1'b1;
                    cnt_q  <= rate_q;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign pend = pend_q;

    // R9: a stopped countdown never holds a request
    a_r9_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q == '0) |-> !pend_q);

endmodule

// File: rtl/sdram_pin_encoder.sv
module sdram_pin_encoder
    import sdram_cmd_pkg::*;
#(
    parameter int MODE_W = 13
) (
    input  logic              issue,
    input  sd_op_e            op,
    input  logic [1:0]        tgt,
    input  logic [MODE_W-1:0] mode,
    output logic [1:0]        cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [MODE_W-1:0] addr
);

    localparam int A10_IDX = 10;

    always_comb begin
        cs_n  = 2'b11;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        if (issue) begin
            unique case (op)
                OP_PRE_ALL: begin
                    cs_n          = ~tgt;
                    ras_n         = 1'b0;
                    we_n          = 1'b0;
                    addr[A10_IDX] = 1'b1;
                end
                OP_AUTO_RF, OP_SELF_RF: begin
                    cs_n  = ~tgt;
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                end
                OP_LOAD_MODE: begin
                    cs_n  = ~tgt;
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                    we_n  = 1'b0;
                    addr  = mode;
                end
                default: begin
                    cs_n = 2'b11;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
    import sdram_cmd_pkg::*;
#(
    parameter int REP_W  = 4,
    parameter int MODE_W = 13,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [OP_W-1:0]   op_in,
    input  logic [1:0]        tgt_in,
    input  logic [REP_W-1:0]  rep_in,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              rf_pend,
    input  logic [TIM_W-1:0]  trc,
    input  logic [TIM_W-1:0]  trp,
    output logic              busy,
    output logic              issue,
    output logic              rf_take,
    output sd_op_e            op_q,
    output logic [1:0]        tgt_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [1:0]        cke_q
);

    eng_state_e        state_q, state_d;
    logic [REP_W-1:0]  rep_q;
    logic [TIM_W-1:0]  gap_q;
    logic [1:0]        cke_next;
    logic              accept, rf_go, gap_done;
    logic [TIM_W-1:0]  trc_eff, trp_eff;

    assign accept   = (state_q == ST_IDLE) && cmd_wr;
    assign rf_take  = (state_q == ST_IDLE) && !cmd_wr && rf_pend;
    assign rf_go    = rf_take && (cke_q != 2'b00);
    assign gap_done = (gap_q <= TIM_W'(1));
    assign trc_eff  = (trc == '0) ? TIM_W'(1) : trc;
    assign trp_eff  = (trp == '0) ? TIM_W'(1) : trp;

    always_comb begin
        unique case (sd_op_e'(op_in))
            OP_NORMAL, OP_CLK_ON:   cke_next = cke_q | tgt_in;
            OP_SELF_RF, OP_PWR_DOWN: cke_next = cke_q & ~tgt_in;
            default:                cke_next = cke_q;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept || rf_go) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (op_q == OP_AUTO_RF || op_q == OP_PRE_ALL) state_d = ST_GAP;
                else                                          state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (gap_done) state_d = (rep_q != '0) ? ST_ISSUE : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NORMAL;
            tgt_q  <= 2'b00;
            rep_q  <= '0;
            mode_q <= '0;
            cke_q  <= 2'b00;
            gap_q  <= '0;
        end else begin
            if (accept) begin
                op_q   <= sd_op_e'(op_in);
                tgt_q  <= tgt_in;
                rep_q  <= rep_in;
                mode_q <= mode_in;
                cke_q  <= cke_next;
            end else if (rf_go) begin
                op_q   <= OP_AUTO_RF;
                tgt_q  <= cke_q;
                rep_q  <= '0;
                mode_q <= '0;
            end
            if (state_q == ST_ISSUE) begin
                gap_q <= (op_q == OP_PRE_ALL) ? trp_eff : trc_eff;
            end
            if (state_q == ST_GAP) begin
                if (!gap_done)          gap_q <= gap_q - 1'b1;
                else if (rep_q != '0)   rep_q <= rep_q - 1'b1;
            end
        end
    end

    assign busy  = (state_q != ST_IDLE);
    assign issue = (state_q == ST_ISSUE);

    // R5: an accepted write makes the engine busy on the next cycle
    a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R6: every auto-refresh issue is followed by a gap
    a_r6_gap_after_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op_q == OP_AUTO_RF) |=> (state_q == ST_GAP));

    // R4: clock enables only move on an accepted write
    a_r4_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cke_q));

endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
    import sdram_cmd_pkg::*;
#(
    parameter int REP_W  = 4,
    parameter int MODE_W = 13,
    parameter int TIM_W  = 4,
    parameter int RATE_W = 13,
    localparam int TGT_LSB  = OP_W,
    localparam int REP_LSB  = TGT_LSB + NUM_DEV,
    localparam int MODE_LSB = REP_LSB + REP_W,
    localparam int CMD_W    = MODE_LSB + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_val,
    input  logic [TIM_W-1:0]  trc_cyc,
    input  logic [TIM_W-1:0]  trp_cyc,
    output logic [1:0]        sd_cs_n,
    output logic [1:0]        sd_cke,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [MODE_W-1:0] sd_addr,
    output logic              busy
);

    logic              rf_pend, rf_take, issue;
    sd_op_e            op_q;
    logic [1:0]        tgt_q;
    logic [MODE_W-1:0] mode_q;

    sdram_rfsh_timer #(.RATE_W(RATE_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_wr (rate_wr),
        .rate_in (rate_val),
        .take    (rf_take),
        .pend    (rf_pend)
    );

    sdram_cmd_fsm #(.REP_W(REP_W), .MODE_W(MODE_W), .TIM_W(TIM_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .op_in   (cmd_word[TGT_LSB-1:0]),
        .tgt_in  (cmd_word[REP_LSB-1:TGT_LSB]),
        .rep_in  (cmd_word[MODE_LSB-1:REP_LSB]),
        .mode_in (cmd_word[CMD_W-1:MODE_LSB]),
        .rf_pend (rf_pend),
        .trc     (trc_cyc),
        .trp     (trp_cyc),
        .busy    (busy),
        .issue   (issue),
        .rf_take (rf_take),
        .op_q    (op_q),
        .tgt_q   (tgt_q),
        .mode_q  (mode_q),
        .cke_q   (sd_cke)
    );

    sdram_pin_encoder #(.MODE_W(MODE_W)) enc_i (
        .issue (issue),
        .op    (op_q),
        .tgt   (tgt_q),
        .mode  (mode_q),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .addr  (sd_addr)
    );

    // R1: the pins are quiet whenever the engine is not busy
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n));

    // R3: a command lasts one cycle, so two issues never touch
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n != 2'b11) |=> (sd_cs_n == 2'b11));

endmodule

// File: tb/sdram_cmd_engine_tb_top.sv
module sdram_cmd_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [21:0] cmd_word = '0;
    logic        rate_wr = 1'b0;
    logic [12:0] rate_val = '0;
    logic [3:0]  trc_cyc = 4'd2;
    logic [3:0]  trp_cyc = 4'd3;
    logic [1:0]  sd_cs_n, sd_cke;
    logic        sd_ras_n, sd_cas_n, sd_we_n, busy;
    logic [12:0] sd_addr;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sdram_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .rate_wr(rate_wr), .rate_val(rate_val), .trc_cyc(trc_cyc), .trp_cyc(trp_cyc),
        .sd_cs_n(sd_cs_n), .sd_cke(sd_cke), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .busy(busy)
    );

    function automatic logic [21:0] mk(input int code, input int tgt, input int rep, input int mode);
        return {13'(mode), 4'(rep), 2'(tgt), 3'(code)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // leaves the bench at the sample point of the issue cycle
    task automatic send(input logic [21:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic watch(input int n, output int busy_n, output int aref_n, output int lmr_n);
        busy_n = 0; aref_n = 0; lmr_n = 0;
        for (int i = 0; i < n; i++) begin
            if (busy) busy_n++;
            if (sd_cs_n != 2'b11 && !sd_ras_n && !sd_cas_n && sd_we_n) aref_n++;
            if (sd_cs_n != 2'b11 && !sd_ras_n && !sd_cas_n && !sd_we_n) lmr_n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(sd_cs_n == 2'b11, "R1 cs_n", sd_cs_n, 2'b11);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 ras/cas/we", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
        chk(sd_cke == 2'b00, "R1 cke", sd_cke, 0);
        chk(busy == 1'b0 && sd_addr == '0, "R1 busy/addr", {busy, sd_addr}, 0);
    endtask

    task automatic t_clk_on();
        send(mk(1, 3, 0, 0));
        chk(sd_cke == 2'b11, "R4 clock enable both", sd_cke, 2'b11);
        chk(sd_cs_n == 2'b11, "R10 clock enable no command", sd_cs_n, 2'b11);
        chk(busy == 1'b1, "R5 busy in issue", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R7 one-cycle busy", busy, 0);
    endtask

    task automatic t_pall();
        int b, a, l;
        trp_cyc = 4'd3;
        send(mk(2, 2, 0, 0));
        chk(sd_cs_n == 2'b01, "R3 precharge device 1 only", sd_cs_n, 2'b01);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b010, "R3 precharge pins", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b010);
        chk(sd_addr[10] == 1'b1, "R3 precharge A10", sd_addr, 13'h400);
        watch(12, b, a, l);
        chk(b == 4, "R7 precharge busy cycles", b, 4);
    endtask

    task automatic t_ignore();
        int b, a, l;
        trp_cyc = 4'd5;
        send(mk(2, 3, 0, 0));
        cmd_wr   = 1'b1;
        cmd_word = mk(4, 3, 0, 13'h155);
        @(negedge clk);
        cmd_wr = 1'b0;
        watch(12, b, a, l);
        chk(l == 0, "R5 write while busy ignored", l, 0);
        chk(b == 5, "R5 busy unaffected by ignored write", b, 5);
    endtask

    task automatic t_lmr();
        int b, a, l;
        send(mk(4, 1, 0, 13'h1632));
        chk(sd_cs_n == 2'b10, "R2 target bit3 is device 2", sd_cs_n, 2'b10);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b000, "R3 load mode pins", {sd_ras_n, sd_cas_n, sd_we_n}, 0);
        chk(sd_addr == 13'h1632, "R2 mode field on address", sd_addr, 13'h1632);
        watch(6, b, a, l);
        chk(b == 1, "R7 load mode busy cycles", b, 1);
    endtask

    task automatic t_aref();
        int b, a, l;
        trc_cyc = 4'd2;
        send(mk(3, 3, 3, 0));
        chk(sd_cs_n == 2'b00, "R3 refresh both devices", sd_cs_n, 0);
        watch(20, b, a, l);
        chk(a == 4, "R6 refresh issue count", a, 4);
        chk(b == 12, "R6 R8 refresh busy cycles", b, 12);
        trc_cyc = 4'd0;
        send(mk(3, 2, 1, 0));
        watch(10, b, a, l);
        chk(a == 2 && b == 4, "R6 zero delay raised to one", b, 4);
        trc_cyc = 4'd0;
        send(mk(3, 2, 15, 0));
        watch(40, b, a, l);
        chk(a == 16 && b == 32, "R6 sixteen repeats", a, 16);
        trc_cyc = 4'd2;
    endtask

    task automatic t_power();
        send(mk(6, 1, 0, 0));
        chk(sd_cke == 2'b10 && sd_cs_n == 2'b11, "R4 power-down device 2", {sd_cke, sd_cs_n}, 4'b1011);
        send(mk(5, 2, 0, 0));
        chk(sd_cke == 2'b00, "R4 self-refresh lowers device 1", sd_cke, 0);
        chk(sd_cs_n == 2'b01 && !sd_ras_n && !sd_cas_n && sd_we_n, "R4 self-refresh pins", sd_cs_n, 2'b01);
        send(mk(7, 3, 0, 0));
        chk(sd_cke == 2'b00 && sd_cs_n == 2'b11, "R10 reserved code no effect", {sd_cke, sd_cs_n}, 4'b0011);
        send(mk(0, 3, 0, 0));
        chk(sd_cke == 2'b11, "R4 normal restores clock enable", sd_cke, 2'b11);
    endtask

    task automatic t_refresh();
        int b, a, l;
        @(negedge clk);
        rate_wr = 1'b1; rate_val = 13'd9;
        @(negedge clk);
        rate_wr = 1'b0;
        @(negedge clk);
        watch(100, b, a, l);
        chk(a == 9, "R9 periodic refresh count", a, 9);
        chk(b == 27, "R9 each refresh busy trc+1", b, 27);
        @(negedge clk);
        rate_wr = 1'b1; rate_val = 13'd0;
        @(negedge clk);
        rate_wr = 1'b0;
        watch(60, b, a, l);
        chk(a == 0, "R9 zero rate stops refresh", a, 0);
    endtask

    task automatic t_refresh_off();
        int b, a, l;
        send(mk(6, 3, 0, 0));
        @(negedge clk);
        rate_wr = 1'b1; rate_val = 13'd4;
        @(negedge clk);
        rate_wr = 1'b0;
        watch(40, b, a, l);
        chk(a == 0 && b == 0, "R10 refresh dropped with clocks off", a, 0);
        @(negedge clk);
        rate_wr = 1'b1; rate_val = 13'd0;
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clk_on();
        t_pall();
        t_ignore();
        t_lmr();
        t_aref();
        t_power();
        t_refresh();
        t_refresh_off();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule